// File: doc/BRIEF.md
# Burst-Capable Bus Master Sequencer

This block is the master side of a 32-bit expansion bus whose address and data share one set of lines. A local requester hands it one longword transfer at a time: a longword address, a direction, byte enables, write data and a flag that says another transfer will follow. The block runs an address phase and then a data phase. It returns the read data, or a completion for a write, as a one-cycle response.

When the requester flags a follow-on transfer and the slave confirms with its burst acknowledge, the cycle stays open after the first beat. Later transfers to the same 256-byte page then run as short cycles. Each short cycle puts a new longword index on the low address lines and pulses the burst strobe, and it skips a new address phase. The slave can withdraw its burst acknowledge. The master samples that acknowledge when the strobe falls, so the short cycle in which it is seen withdrawn is the last one. A request outside the open page, or a beat whose follow-on flag is clear, closes the cycle. The next request then starts with a fresh address phase.

The slave's select, burst acknowledge and data acknowledge are each taken through a two-flop synchroniser before the sequencer uses them. All bus outputs come straight from registers.

Top module: `burst_bus_master`

## Requirements
- R1: While reset is held and straight after it, fcs_n, mtcr_n and all ds_n bits are high, doe is low, rsp_valid is low and req_ready is high.
- R2: An accepted request from idle starts an address phase. fcs_n falls with ad_out = {req_lwaddr, 2'b00} and ad_oe high. In that same cycle mtcr_n is low exactly when req_more was 1.
- R3: In the data phase doe is high. ds_n[i] is low exactly when byte enable bit i is 1, and during writes ad_out carries the write data with ad_oe high. doe and ds_n are only active while fcs_n is low.
- R4: If no burst was requested, or mtack_n is still high when the slave's select is seen, the transfer is a plain cycle. At the end of its beat fcs_n, all ds_n bits and doe are released together, and mtcr_n is high.
- R5: To continue a burst after a beat, ds_n and mtcr_n are released while fcs_n stays low and doe stays high.
- R6: A short cycle sets low_addr to the request's longword bits [5:0] and sets read to the new direction one cycle before mtcr_n falls. low_addr holds while mtcr_n is low. For a read, ds_n goes active in the same cycle as the mtcr_n fall. For a write, ds_n and the write data follow one cycle later.
- R7: mtack_n is sampled on a registered falling-edge event of mtcr_n. If it is seen high, the current short cycle is the last, and fcs_n and doe are released with mtcr_n when it ends.
- R8: When the beat just finished had req_more = 0, the open cycle ends at that beat, and the next request gets a new address phase.
- R9: During an open burst, req_ready is high only for a request whose longword bits [29:6] match the latched page. A request outside the page closes the open cycle and is then served with a new full cycle. An accepted in-page request keeps fcs_n low.
- R10: Read data is captured from ad_in once the synchronised dtack_n is low. It is returned on rsp_rdata with a one-cycle rsp_valid pulse. Writes also end with such a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester offers a transfer |
| req_ready | output | 1 | Transfer is accepted at this edge |
| req_lwaddr | input | 30 | Longword address of the transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables, bit i = byte lane i |
| req_wdata | input | 32 | Write data |
| req_more | input | 1 | Another transfer follows this one |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data of the completed transfer |
| fcs_n | output | 1 | Full-cycle strobe, active low |
| mtcr_n | output | 1 | Burst request / short-cycle strobe, active low |
| doe | output | 1 | Data phase enable |
| ds_n | output | 4 | Byte lane strobes, active low |
| read | output | 1 | 1 = read cycle |
| ad_out | output | 32 | Address or write data driven on the shared lines |
| ad_oe | output | 1 | Drive enable for ad_out |
| low_addr | output | 6 | Non-multiplexed longword index within the page |
| ad_in | input | 32 | Shared lines as driven by the slave |
| slave_n | input | 1 | Slave select response, active low |
| mtack_n | input | 1 | Slave burst acknowledge, active low |
| dtack_n | input | 1 | Slave data acknowledge, active low |

## Verification
The assertions assume that every request carries at least one byte enable. Without one, a short read would show no lane strobe when mtcr_n falls. They also assume that the slave keeps dtack_n low and ad_in steady until the master releases ds_n, and that it changes mtack_n only at its own select response or while releasing dtack_n. The bench slave model answers at negative clock edges and withdraws mtack_n only as it releases dtack_n after a chosen beat count. The random requests always use byte enables from 1 to 15, which keeps the stimulus inside these assumptions.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef enum logic [3:0] {
        BM_IDLE,
        BM_ADDR,
        BM_DATA,
        BM_REL,
        BM_GAP,
        BM_SSET,
        BM_SSTRB,
        BM_SDATA,
        BM_END
    } bm_state_e;

endpackage

// File: rtl/bbm_sync.sv
module bbm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '1;
                else        chain_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '1;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/bbm_seq.sv
module bbm_seq
    import bbm_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int NBE       = 4,
    parameter int PAGE_BITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [AW-3:0]      req_lwaddr,
    input  logic               req_write,
    input  logic [NBE-1:0]     req_be,
    input  logic [DW-1:0]      req_wdata,
    input  logic               req_more,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_rdata,
    output logic               fcs_n,
    output logic               mtcr_n,
    output logic               doe,
    output logic [NBE-1:0]     ds_n,
    output logic               read,
    output logic [AW-1:0]      ad_out,
    output logic               ad_oe,
    output logic [PAGE_BITS-3:0] low_addr,
    input  logic [DW-1:0]      ad_in,
    input  logic               slave_s,
    input  logic               mtack_s,
    input  logic               dtack_s
);

    localparam int LW_W  = AW - 2;
    localparam int LOW_W = PAGE_BITS - 2;
    localparam int UP_W  = AW - PAGE_BITS;

    typedef struct packed {
        bm_state_e      st;
        logic           fcs_n;
        logic           mtcr_n;
        logic           mtcr_prev;
        logic           doe;
        logic [NBE-1:0] ds_n;
        logic           rd;
        logic [AW-1:0]  ad;
        logic           ad_oe;
        logic [LOW_W-1:0] lo;
        logic [UP_W-1:0]  up;
        logic [NBE-1:0] be;
        logic [DW-1:0]  wdata;
        logic           more;
        logic           cont;
        logic [DW-1:0]  rdata;
        logic           rsp;
    } regs_t;

    regs_t r_q, r_d;
    logic  in_page;
    logic  mtcr_fall;

    assign in_page   = (req_lwaddr[LW_W-1:LOW_W] == r_q.up);
    assign mtcr_fall = r_q.mtcr_prev & ~r_q.mtcr_n;

    always_comb begin
        r_d           = r_q;
        r_d.rsp       = 1'b0;
        r_d.mtcr_prev = r_q.mtcr_n;
        req_ready     = 1'b0;
        case (r_q.st)
            BM_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.st     = BM_ADDR;
                    r_d.fcs_n  = 1'b0;
                    r_d.mtcr_n = ~req_more;
                    r_d.ad     = {req_lwaddr, 2'b00};
                    r_d.ad_oe  = 1'b1;
                    r_d.rd     = ~req_write;
                    r_d.lo     = req_lwaddr[LOW_W-1:0];
                    r_d.up     = req_lwaddr[LW_W-1:LOW_W];
                    r_d.be     = req_be;
                    r_d.wdata  = req_wdata;
                    r_d.more   = req_more;
                    r_d.cont   = 1'b0;
                end
            end
            BM_ADDR: begin
                if (!slave_s) begin
                    r_d.st    = BM_DATA;
                    r_d.cont  = ~r_q.mtcr_n & ~mtack_s;
                    r_d.doe   = 1'b1;
                    r_d.ds_n  = ~r_q.be;
                    r_d.ad    = r_q.wdata;
                    r_d.ad_oe = ~r_q.rd;
                end
            end
            BM_DATA, BM_SDATA: begin
                if (!dtack_s) begin
                    r_d.rdata  = ad_in;
                    r_d.rsp    = 1'b1;
                    r_d.ds_n   = '1;
                    r_d.mtcr_n = 1'b1;
                    r_d.ad_oe  = 1'b0;
                    if (r_q.more && r_q.cont) begin
                        r_d.st = BM_REL;
                    end else begin
                        r_d.st    = BM_END;
                        r_d.fcs_n = 1'b1;
                        r_d.doe   = 1'b0;
                    end
                end
            end
            BM_REL: begin
                if (dtack_s) r_d.st = BM_GAP;
            end
            BM_GAP: begin
                if (req_valid) begin
                    if (in_page) begin
                        req_ready = 1'b1;
                        r_d.st    = BM_SSET;
                        r_d.lo    = req_lwaddr[LOW_W-1:0];
                        r_d.rd    = ~req_write;
                        r_d.be    = req_be;
                        r_d.wdata = req_wdata;
                        r_d.more  = req_more;
                    end else begin
                        r_d.st    = BM_END;
                        r_d.fcs_n = 1'b1;
                        r_d.doe   = 1'b0;
                    end
                end
            end
            BM_SSET: begin
                r_d.st     = BM_SSTRB;
                r_d.mtcr_n = 1'b0;
                r_d.ds_n   = r_q.rd ? ~r_q.be : '1;
            end
            BM_SSTRB: begin
                if (mtcr_fall) r_d.cont = ~mtack_s;
                r_d.st    = BM_SDATA;
                r_d.ds_n  = ~r_q.be;
                r_d.ad    = r_q.wdata;
                r_d.ad_oe = ~r_q.rd;
            end
            BM_END: begin
                if (dtack_s && slave_s) r_d.st = BM_IDLE;
            end
            default: r_d.st = BM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= BM_IDLE;
            r_q.fcs_n     <= 1'b1;
            r_q.mtcr_n    <= 1'b1;
            r_q.mtcr_prev <= 1'b1;
            r_q.ds_n      <= '1;
            r_q.rd        <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign fcs_n     = r_q.fcs_n;
    assign mtcr_n    = r_q.mtcr_n;
    assign doe       = r_q.doe;
    assign ds_n      = r_q.ds_n;
    assign read      = r_q.rd;
    assign ad_out    = r_q.ad;
    assign ad_oe     = r_q.ad_oe;
    assign low_addr  = r_q.lo;
    assign rsp_valid = r_q.rsp;
    assign rsp_rdata = r_q.rdata;

    AST_DOE_INSIDE_FCS: assert property (@(posedge clk) disable iff (!rst_n)
        doe |-> !fcs_n);                                                     // R3
    AST_DS_INSIDE_DOE: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_n != '1) |-> doe);                                               // R3
    AST_FULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fcs_n) |-> (!doe && (ds_n == '1) && mtcr_n));                  // R4
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(&ds_n) && !fcs_n) |-> (doe && mtcr_n));                       // R5
    AST_SHORT_READ_DS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mtcr_n) && $past(!fcs_n) && read) |-> (ds_n != '1));          // R6
    AST_SHORT_WRITE_DS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mtcr_n) && $past(!fcs_n) && !read) |-> (&ds_n));              // R6
    AST_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mtcr_n && $past(!mtcr_n) && !fcs_n) |-> $stable(low_addr));        // R6
    AST_FALL_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        mtcr_fall |-> (r_q.st == BM_ADDR || r_q.st == BM_SSTRB));            // R7
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !fcs_n) |=> !fcs_n);                      // R9

endmodule

// File: rtl/burst_bus_master.sv
module burst_bus_master #(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int NBE         = 4,
    parameter int PAGE_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [AW-3:0]        req_lwaddr,
    input  logic                 req_write,
    input  logic [NBE-1:0]       req_be,
    input  logic [DW-1:0]        req_wdata,
    input  logic                 req_more,
    output logic                 rsp_valid,
    output logic [DW-1:0]        rsp_rdata,
    output logic                 fcs_n,
    output logic                 mtcr_n,
    output logic                 doe,
    output logic [NBE-1:0]       ds_n,
    output logic                 read,
    output logic [AW-1:0]        ad_out,
    output logic                 ad_oe,
    output logic [PAGE_BITS-3:0] low_addr,
    input  logic [DW-1:0]        ad_in,
    input  logic                 slave_n,
    input  logic                 mtack_n,
    input  logic                 dtack_n
);

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] sync_q;

    bbm_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({slave_n, mtack_n, dtack_n}),
        .q     (sync_q)
    );

    bbm_seq #(.AW(AW), .DW(DW), .NBE(NBE), .PAGE_BITS(PAGE_BITS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_lwaddr (req_lwaddr),
        .req_write  (req_write),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .req_more   (req_more),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .fcs_n      (fcs_n),
        .mtcr_n     (mtcr_n),
        .doe        (doe),
        .ds_n       (ds_n),
        .read       (read),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .low_addr   (low_addr),
        .ad_in      (ad_in),
        .slave_s    (sync_q[2]),
        .mtack_s    (sync_q[1]),
        .dtack_s    (sync_q[0])
    );

endmodule

// File: tb/burst_bus_master_test.sv
module burst_bus_master_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [29:0] req_lwaddr = '0;
    logic        req_write = 1'b0;
    logic [3:0]  req_be = 4'hF;
    logic [31:0] req_wdata = '0;
    logic        req_more = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        fcs_n, mtcr_n, doe, read, ad_oe;
    logic [3:0]  ds_n;
    logic [31:0] ad_out;
    logic [5:0]  low_addr;
    logic [31:0] ad_in = '0;
    logic        slave_n = 1'b1;
    logic        mtack_n = 1'b1;
    logic        dtack_n = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_bus_master uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_lwaddr(req_lwaddr), .req_write(req_write), .req_be(req_be),
        .req_wdata(req_wdata), .req_more(req_more), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .fcs_n(fcs_n), .mtcr_n(mtcr_n), .doe(doe),
        .ds_n(ds_n), .read(read), .ad_out(ad_out), .ad_oe(ad_oe),
        .low_addr(low_addr), .ad_in(ad_in), .slave_n(slave_n),
        .mtack_n(mtack_n), .dtack_n(dtack_n)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_fn(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A3C_0F96;
    endfunction

    // slave configuration and records
    bit          sup = 1'b1;
    int          lim = 100;
    bit          s_act = 1'b0;
    logic [23:0] s_up = '0;
    int          s_beats = 0;
    logic [31:0] w_addr = '0, w_data = '0;
    logic [3:0]  w_ds = '1;

    // current request, visible to monitors
    logic [29:0] cur_lw = '0;
    logic        cur_wr = 1'b0, cur_more = 1'b0;
    logic [3:0]  cur_be = '0;
    logic [31:0] cur_wd = '0;
    int          obs_full = 0;

    // slave model, acts on falling edges
    always @(negedge clk) begin
        if (!rst_n) begin
            slave_n = 1'b1; mtack_n = 1'b1; dtack_n = 1'b1; s_act = 1'b0;
        end else begin
            if (!fcs_n && !s_act) begin
                s_act = 1'b1; s_up = ad_out[31:8]; s_beats = 0;
                slave_n = 1'b0; mtack_n = sup ? 1'b0 : 1'b1;
            end else if (fcs_n && s_act) begin
                s_act = 1'b0; slave_n = 1'b1; mtack_n = 1'b1;
            end
            if (s_act && ds_n != 4'hF && dtack_n) begin
                if (read) ad_in = rd_fn({s_up, low_addr, 2'b00});
                else begin
                    w_addr = {s_up, low_addr, 2'b00}; w_data = ad_out; w_ds = ds_n;
                end
                dtack_n = 1'b0;
            end else if (ds_n == 4'hF && !dtack_n) begin
                dtack_n = 1'b1;
                s_beats++;
                if (s_beats >= lim) mtack_n = 1'b1;
            end
        end
    end

    // bus protocol monitor
    logic       p_fcs = 1'b1, p_mtcr = 1'b1, wr_pend = 1'b0;
    logic [3:0] p_ds = '1;
    logic [5:0] p_lo = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_pend) begin
                chk(ds_n == ~cur_be, "R6 short write lanes one cycle after strobe", {28'h0, ds_n}, {28'h0, ~cur_be});
                chk(ad_out == cur_wd && ad_oe, "R6 short write data", ad_out, cur_wd);
                wr_pend = 1'b0;
            end
            if (p_fcs && !fcs_n) begin
                obs_full++;
                chk(ad_out == {cur_lw, 2'b00} && ad_oe, "R2 address phase", ad_out, {cur_lw, 2'b00});
                chk(mtcr_n == ~cur_more, "R2 burst request with address", {31'h0, mtcr_n}, {31'h0, ~cur_more});
            end
            if (p_ds != 4'hF && ds_n == 4'hF) begin
                if (!fcs_n) chk(doe && mtcr_n, "R5 burst hold after beat", {30'h0, doe, mtcr_n}, 32'h3);
                else        chk(!doe && mtcr_n, "R4 full release", {30'h0, doe, mtcr_n}, 32'h1);
            end
            if (!fcs_n && doe && ds_n != 4'hF)
                chk(ds_n == ~cur_be, "R3 lane strobes match enables", {28'h0, ds_n}, {28'h0, ~cur_be});
            if (p_mtcr && !mtcr_n && !p_fcs) begin
                chk(low_addr == cur_lw[5:0] && p_lo == cur_lw[5:0], "R6 low address set before strobe", {26'h0, p_lo}, {26'h0, cur_lw[5:0]});
                chk(read == ~cur_wr, "R6 direction in short cycle", {31'h0, read}, {31'h0, ~cur_wr});
                if (cur_wr) begin
                    chk(ds_n == 4'hF, "R6 write lanes idle at strobe", {28'h0, ds_n}, 32'hF);
                    wr_pend = 1'b1;
                end else
                    chk(ds_n == ~cur_be, "R6 read lanes with strobe", {28'h0, ds_n}, {28'h0, ~cur_be});
            end
        end
        p_fcs = fcs_n; p_mtcr = mtcr_n; p_ds = ds_n; p_lo = low_addr;
    end

    // reference model of how many address phases occur
    bit          m_open = 1'b0;
    logic [23:0] m_page = '0;
    int          m_beats = 0;
    int          m_full = 0;

    task automatic do_req(input logic [29:0] lw, input bit wr, input logic [3:0] be,
                          input logic [31:0] wd, input bit more, input string tag);
        bit is_short;
        is_short = m_open && (lw[29:6] == m_page);
        if (!is_short) begin
            m_full++; m_page = lw[29:6]; m_beats = 1; m_open = more && sup;
        end else begin
            m_beats++;
            if (m_beats > lim) m_open = 1'b0;
            if (!more) m_open = 1'b0;
        end
        @(negedge clk);
        cur_lw = lw; cur_wr = wr; cur_be = be; cur_wd = wd; cur_more = more;
        req_lwaddr = lw; req_write = wr; req_be = be; req_wdata = wd; req_more = more;
        req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        if (!wr) chk(rsp_rdata == rd_fn({lw, 2'b00}), "R10 read data", rsp_rdata, rd_fn({lw, 2'b00}));
        else begin
            chk(w_addr == {lw, 2'b00}, "R6 write address seen by slave", w_addr, {lw, 2'b00});
            chk(w_data == wd, "R3 write data", w_data, wd);
            chk(w_ds == ~be, "R3 write lanes", {28'h0, w_ds}, {28'h0, ~be});
        end
        chk(obs_full == m_full, tag, obs_full, m_full);
    endtask

    localparam logic [23:0] PG0 = 24'h40_1200;

    initial begin
        void'($urandom(32'h0005_EED1));
        repeat (3) @(negedge clk);
        chk(fcs_n && mtcr_n && ds_n == 4'hF && !doe, "R1 bus idle in reset", {26'h0, fcs_n, mtcr_n, ds_n}, 32'h3F);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(req_ready && !rsp_valid, "R1 ready after reset", {30'h0, req_ready, rsp_valid}, 32'h2);

        // plain cycles
        do_req({PG0, 6'd3}, 1'b0, 4'hF, 32'h0, 1'b0, "R4 plain read count");
        do_req({PG0, 6'd4}, 1'b1, 4'h5, 32'hCAFE_0001, 1'b0, "R4 plain write count");
        // burst of reads and writes, ended by requester
        lim = 100;
        do_req({PG0, 6'd0},  1'b0, 4'hF, 32'h0, 1'b1, "R5 burst start");
        do_req({PG0, 6'd63}, 1'b0, 4'h3, 32'h0, 1'b1, "R6 short read");
        do_req({PG0, 6'd17}, 1'b1, 4'hC, 32'h1234_5678, 1'b1, "R6 short write");
        do_req({PG0, 6'd2},  1'b0, 4'h1, 32'h0, 1'b0, "R8 last by requester");
        do_req({PG0, 6'd5},  1'b0, 4'hF, 32'h0, 1'b0, "R8 new address phase after end");
        // page change inside burst
        do_req({PG0, 6'd9},  1'b0, 4'hF, 32'h0, 1'b1, "R9 burst open");
        do_req({PG0 + 24'd1, 6'd9}, 1'b1, 4'hF, 32'hA5A5_0F0F, 1'b1, "R9 page change forces full cycle");
        do_req({PG0 + 24'd1, 6'd10}, 1'b0, 4'hF, 32'h0, 1'b0, "R9 same page stays short");
        // slave limits the burst
        lim = 1;
        do_req({PG0, 6'd1}, 1'b0, 4'hF, 32'h0, 1'b1, "R7 burst start with limit");
        do_req({PG0, 6'd2}, 1'b1, 4'hF, 32'h0BAD_F00D, 1'b1, "R7 last short after withdraw");
        do_req({PG0, 6'd3}, 1'b0, 4'hF, 32'h0, 1'b0, "R7 new full after withdraw");
        // slave without burst support
        sup = 1'b0; lim = 100;
        do_req({PG0, 6'd7}, 1'b0, 4'hF, 32'h0, 1'b1, "R4 no burst acknowledge");
        do_req({PG0, 6'd8}, 1'b1, 4'h9, 32'h7777_1111, 1'b0, "R4 no burst acknowledge second");

        // constrained random
        for (int ph = 0; ph < 6; ph++) begin
            sup = (ph != 4);
            lim = 1 + (ph % 4);
            for (int i = 0; i < 60; i++) begin
                logic [29:0] lw;
                lw = {PG0 + 24'($urandom % 3), 6'($urandom)};
                do_req(lw, 1'($urandom), 4'(($urandom % 15) + 1), $urandom,
                       (i == 59) ? 1'b0 : (($urandom % 10) < 7), "R9 random address phase count");
            end
        end

        repeat (10) @(negedge clk);
        chk(fcs_n && doe == 1'b0, "R8 bus released at end", {30'h0, fcs_n, doe}, 32'h2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R10 actual=hung expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule